// File: doc/BRIEF.md
# Pipelined Integer Multiplier with High-Half Variants

This block multiplies two 64-bit integer operands and returns either the low or the high 64 bits of the full product, or a 32-bit word product. The result appears exactly two clock cycles after the operation is presented. A new operation may enter on every cycle, so a stream of operations comes out in issue order at one result per cycle.

A 5-bit operation code picks the variant. Bits 4..3 are the operation class, and only class `00` (multiply) is accepted. Bit 2 selects word mode. Bits 1..0 select the variant. Every variant runs on one 65-bit signed multiply core. Each operand is widened by one bit: the sign bit is copied in when the operand is treated as signed, and a zero is added when it is treated as unsigned.

Top module: `pipe_mul`

## Requirements
- R1: Only operation codes whose bits 4..3 are `00` are accepted. Any other class presented with `in_valid_i` produces no result: `out_valid_o` stays low two cycles later.
- R2: An accepted operation presented at a rising edge raises `out_valid_o` after exactly the second rising edge that follows. Otherwise `out_valid_o` is low.
- R3: Code `0x00` returns the low 64 bits of `a_i * b_i`.
- R4: Code `0x01` returns the high 64 bits of the 128-bit product, with both operands signed.
- R5: Code `0x02` returns the high 64 bits of the product of a signed `a_i` and an unsigned `b_i`.
- R6: Code `0x03` returns the high 64 bits of the product, with both operands unsigned.
- R7: Code `0x04` multiplies the low 32 bits of each operand. It returns the low 32 bits of that product, sign-extended to 64 bits. Operand bits 63..32 have no effect. Codes `0x05`..`0x07` behave the same as `0x04`.
- R8: Operations issued on consecutive cycles produce results on consecutive cycles, in issue order, with no bubble.
- R9: After reset, `out_valid_o` is 0 and `result_o` is 0. `result_o` keeps its last value on every cycle in which `out_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code: class [4:3], word [2], variant [1:0] |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| out_valid_o | output | 1 | Result present this cycle |
| result_o | output | 64 | Result data |

## Verification
The latency and drop properties assume that `op_i` and the operands are known whenever `in_valid_i` is high, and that reset is held for at least one clock edge. The bench always drives fully defined values. It drives on the falling edge, and it sends undefined or non-multiply codes only as deliberate cases for R1. Stimulus includes long back-to-back runs mixed with idle cycles. The operand corners are the most negative value, all ones and zero, so the sign and zero extension paths are exercised both ways.

// File: rtl/pipe_mul_pkg.sv
package pipe_mul_pkg;
  localparam int unsigned OP_W = 5;

  localparam logic [1:0] CLS_MUL = 2'b00;

  // variant field bits 1..0
  localparam logic [1:0] VAR_LO    = 2'b00;
  localparam logic [1:0] VAR_HI_SS = 2'b01;
  localparam logic [1:0] VAR_HI_SU = 2'b10;
  localparam logic [1:0] VAR_HI_UU = 2'b11;

  typedef struct packed {
    logic is_mul;
    logic hi;
    logic word;
    logic a_sgn;
    logic b_sgn;
  } mul_ctrl_t;
endpackage

// File: rtl/pipe_mul_decode.sv
module pipe_mul_decode
  import pipe_mul_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output mul_ctrl_t       ctrl_o
);
  logic [1:0] cls;
  logic [1:0] var_sel;

  assign cls     = op_i[4:3];
  assign var_sel = op_i[1:0];

  always_comb begin
    ctrl_o        = '0;
    ctrl_o.is_mul = (cls == CLS_MUL);
    ctrl_o.word   = op_i[2];
    // word mode keeps only low bits; variant bits then do not matter
    ctrl_o.hi     = !op_i[2] && (var_sel != VAR_LO);
    unique case (var_sel)
      VAR_LO:    begin ctrl_o.a_sgn = 1'b1; ctrl_o.b_sgn = 1'b1; end
      VAR_HI_SS: begin ctrl_o.a_sgn = 1'b1; ctrl_o.b_sgn = 1'b1; end
      VAR_HI_SU: begin ctrl_o.a_sgn = 1'b1; ctrl_o.b_sgn = 1'b0; end
      default:   begin ctrl_o.a_sgn = 1'b0; ctrl_o.b_sgn = 1'b0; end
    endcase
    if (op_i[2]) begin
      ctrl_o.a_sgn = 1'b1;
      ctrl_o.b_sgn = 1'b1;
    end
  end
endmodule

// File: rtl/pipe_mul_opext.sv
module pipe_mul_opext #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CORE_W = XLEN + 1
) (
  input  logic [XLEN-1:0]   data_i,
  input  logic              sgn_i,
  input  logic              word_i,
  output logic [CORE_W-1:0] ext_o
);
  logic fill_full;
  logic fill_word;

  assign fill_full = sgn_i & data_i[XLEN-1];
  assign fill_word = sgn_i & data_i[WORD_W-1];

  always_comb begin
    if (word_i) ext_o = {{(CORE_W-WORD_W){fill_word}}, data_i[WORD_W-1:0]};
    else        ext_o = {fill_full, data_i};
  end
endmodule

// File: rtl/pipe_mul_core.sv
module pipe_mul_core #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CORE_W = XLEN + 1,
  localparam int unsigned PROD_W = 2 * XLEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              hi_i,
  input  logic              word_i,
  input  logic [CORE_W-1:0] a_i,
  input  logic [CORE_W-1:0] b_i,
  output logic              valid_o,
  output logic [XLEN-1:0]   result_o
);
  // stage 1: captured operands
  logic              s1_valid_q;
  logic              s1_hi_q;
  logic              s1_word_q;
  logic [CORE_W-1:0] s1_a_q;
  logic [CORE_W-1:0] s1_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_hi_q    <= 1'b0;
      s1_word_q  <= 1'b0;
      s1_a_q     <= '0;
      s1_b_q     <= '0;
    end else begin
      s1_valid_q <= valid_i;
      if (valid_i) begin
        s1_hi_q   <= hi_i;
        s1_word_q <= word_i;
        s1_a_q    <= a_i;
        s1_b_q    <= b_i;
      end
    end
  end

  // product modulo 2^PROD_W is all any variant needs
  logic [PROD_W-1:0] a_wide;
  logic [PROD_W-1:0] b_wide;
  logic [PROD_W-1:0] prod;
  logic [XLEN-1:0]   sel;

  assign a_wide = {{(PROD_W-CORE_W){s1_a_q[CORE_W-1]}}, s1_a_q};
  assign b_wide = {{(PROD_W-CORE_W){s1_b_q[CORE_W-1]}}, s1_b_q};
  assign prod   = a_wide * b_wide;

  always_comb begin
    if (s1_word_q)    sel = {{(XLEN-WORD_W){prod[WORD_W-1]}}, prod[WORD_W-1:0]};
    else if (s1_hi_q) sel = prod[PROD_W-1:XLEN];
    else              sel = prod[XLEN-1:0];
  end

  // stage 2: result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= s1_valid_q;
      if (s1_valid_q) result_o <= sel;
    end
  end

  // R9: output holds while idle
  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));
  // R2: stage 1 feeds stage 2 one cycle later
  a_r2_stage_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_q |=> valid_o);
endmodule

// File: rtl/pipe_mul.sv
module pipe_mul
  import pipe_mul_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CORE_W = XLEN + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            out_valid_o,
  output logic [XLEN-1:0] result_o
);
  mul_ctrl_t ctrl;

  pipe_mul_decode u_dec (
    .op_i  (op_i),
    .ctrl_o(ctrl)
  );

  logic [XLEN-1:0]   opd [2];
  logic              sgn [2];
  logic [CORE_W-1:0] ext [2];

  assign opd[0] = a_i;
  assign opd[1] = b_i;
  assign sgn[0] = ctrl.a_sgn;
  assign sgn[1] = ctrl.b_sgn;

  for (genvar i = 0; i < 2; i++) begin : g_ext
    pipe_mul_opext #(.XLEN(XLEN), .WORD_W(WORD_W)) u_ext (
      .data_i(opd[i]),
      .sgn_i (sgn[i]),
      .word_i(ctrl.word),
      .ext_o (ext[i])
    );
  end

  pipe_mul_core #(.XLEN(XLEN), .WORD_W(WORD_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i & ctrl.is_mul),
    .hi_i    (ctrl.hi),
    .word_i  (ctrl.word),
    .a_i     (ext[0]),
    .b_i     (ext[1]),
    .valid_o (out_valid_o),
    .result_o(result_o)
  );

  // R2: fixed two-cycle latency
  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i[4:3] == CLS_MUL) |-> ##2 out_valid_o);
  // R1: other classes are dropped
  a_r1_drop_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i || op_i[4:3] != CLS_MUL) |-> ##2 !out_valid_o);
  // R7: word result is sign-extended
  a_r7_word_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i[4:2] == 3'b001) |-> ##2
      (result_o[XLEN-1:WORD_W] == {(XLEN-WORD_W){result_o[WORD_W-1]}}));
endmodule

// File: tb/pipe_mul_bench.sv
module pipe_mul_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        out_valid;
  logic [63:0] result;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_mul u_pipe_mul (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .op_i(op),
    .a_i(a), .b_i(b), .out_valid_o(out_valid), .result_o(result)
  );

  // behavioural reference
  function automatic logic [63:0] ref_mul(logic [4:0] o, logic [63:0] x, logic [63:0] y);
    logic [127:0] xw, yw, p;
    logic [63:0]  pw;
    if (o[2]) begin
      pw = 64'(x[31:0]) * 64'(y[31:0]);
      return {{32{pw[31]}}, pw[31:0]};
    end
    case (o[1:0])
      2'd1:    begin xw = {{64{x[63]}}, x}; yw = {{64{y[63]}}, y}; end
      2'd2:    begin xw = {{64{x[63]}}, x}; yw = {64'd0, y}; end
      default: begin xw = {64'd0, x}; yw = {64'd0, y}; end
    endcase
    p = xw * yw;
    return (o[1:0] == 2'd0) ? p[63:0] : p[127:64];
  endfunction

  function automatic string tag_of(logic v, logic [4:0] o);
    if (!v)            return "R9";
    if (o[4:3] != 2'b00) return "R1";
    if (o[2])          return "R7";
    case (o[1:0])
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // two-deep history of issued operations
  logic        h1_v = 0, h2_v = 0;
  logic [63:0] h1_r = 0, h2_r = 0;
  string       h1_t = "R9", h2_t = "R9";
  logic [63:0] last_res = 0;

  task automatic step(logic v, logic [4:0] o, logic [63:0] x, logic [63:0] y);
    logic acc;
    @(negedge clk);
    total++;
    if (h2_v) begin
      // R2 R8: result two cycles after issue, in order
      if (out_valid !== 1'b1 || result !== h2_r) begin
        bad++;
        $display("FAIL %s/R2/R8: valid=%0b result=%h expected valid=1 result=%h",
                 h2_t, out_valid, result, h2_r);
      end
      last_res = h2_r;
    end else begin
      if (out_valid !== 1'b0 || result !== last_res) begin
        bad++;
        $display("FAIL %s: valid=%0b result=%h expected valid=0 result=%h",
                 h2_t, out_valid, result, last_res);
      end
    end
    acc  = v && (o[4:3] == 2'b00);
    h2_v = h1_v; h2_r = h1_r; h2_t = h1_t;
    h1_v = acc;  h1_r = acc ? ref_mul(o, x, y) : 64'd0; h1_t = tag_of(acc || !v ? acc : 1'b1, o);
    if (v && !acc) h1_t = "R1";
    in_valid = v; op = o; a = x; b = y;
  endtask

  localparam logic [63:0] MIN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    total++;
    // R9: reset state
    if (out_valid !== 1'b0 || result !== 64'd0) begin
      bad++;
      $display("FAIL R9: reset valid=%0b result=%h expected 0/0", out_valid, result);
    end
    rst_ni = 1'b1;

    // R3..R6 corners, back to back (R8)
    step(1, 5'h00, MIN, MIN);
    step(1, 5'h01, MIN, MIN);
    step(1, 5'h01, ONES, ONES);
    step(1, 5'h02, ONES, ONES);
    step(1, 5'h02, MIN, ONES);
    step(1, 5'h03, ONES, ONES);
    step(1, 5'h03, ONES, 64'd0);
    step(1, 5'h00, ONES, 64'd7);
    // R7: word, upper bits ignored, 0x05..0x07 alias
    step(1, 5'h04, 64'hdead_beef_7fff_ffff, 64'h1234_5678_0000_0002);
    step(1, 5'h04, 64'h0000_0000_8000_0000, 64'hffff_ffff_0000_0001);
    step(1, 5'h05, 64'h0000_0001_ffff_ffff, 64'h5);
    step(1, 5'h06, 64'h0000_1000, 64'h0010_0000);
    step(1, 5'h07, ONES, ONES);
    // R1: other classes dropped
    step(1, 5'h08, 64'd3, 64'd4);
    step(1, 5'h10, 64'd3, 64'd4);
    step(1, 5'h19, 64'd3, 64'd4);
    // R9: idle keeps result
    step(0, 5'h00, 64'd9, 64'd9);
    step(0, 5'h00, 64'd9, 64'd9);
    step(0, 5'h00, 64'd9, 64'd9);

    // random stream with gaps and foreign classes
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] o;
      logic [63:0] x, y;
      int sel;
      sel = $urandom_range(0, 15);
      o = {2'b00, 3'($urandom_range(0, 7))};
      if (sel == 0) o[4:3] = 2'($urandom_range(1, 3));
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if (sel == 1) x = MIN;
      if (sel == 2) y = ONES;
      step(sel != 3, o, x, y);
    end
    step(0, 5'h00, 0, 0);
    step(0, 5'h00, 0, 0);
    step(0, 5'h00, 0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule